// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a CPU core and turns five interrupt request lines into a single request toward the core. It also delivers a 16-bit service address for whichever request the core accepts. Four of the lines have fixed service addresses. The fifth, the general line, has no address of its own. When the core accepts it, the block drives an active-low acknowledge pulse and captures the instruction byte that external logic places on the data bus. A restart opcode in that byte is converted into its service address.

The core controls the block through three strobes. One sets the global enable, one clears it, and one loads a three-bit mask register. The non-maskable line ignores both the enable and the mask. The three restart lines need the enable set and their own mask bit clear. The general line needs only the enable. The core raises `take_i` while `irq_req_o` is high to accept the winning request. The block then runs a short sequence that ends with a one-cycle `vec_valid_o` strobe. Accepting any interrupt clears the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several sources are eligible, the one accepted is chosen by the fixed order: non-maskable line (highest), edge restart line, restart line B, restart line C, general line (lowest).
- R2: For a fixed-vector source, `vec_valid_o` is high for exactly one cycle, in the cycle after the accept. In that cycle `vec_addr_o` is 0x0024 for the non-maskable line, 0x003C for the edge line, 0x0034 for line B and 0x002C for line C. `src_o` is one-hot with bit 0 for the non-maskable line, bit 1 for the edge line, bit 2 for line B, bit 3 for line C and bit 4 for the general line.
- R3: A high `trap_i` raises `irq_req_o` whenever no sequence is running, whatever the global enable and the mask.
- R4: A rising edge on `rst75_i` sets a pending flag that stays set after the line falls. The flag is cleared only when that source is accepted. If a new rising edge arrives in the same cycle as that accept, the flag stays set.
- R5: `rst65_i` and `rst55_i` are level-sensitive and eligible only while the global enable is set and their mask bit is clear. `mask_i` bit 0 masks line C, bit 1 masks line B and bit 2 masks the edge line. A mask write takes effect in the following cycle.
- R6: `intr_i` is level-sensitive, is eligible whenever the global enable is set, and is unaffected by the mask register.
- R7: After a general-line accept, `inta_n_o` is low for INTA_CYCLES cycles (default 2), starting in the cycle after the accept. `data_i` is sampled in the last low cycle. `vec_valid_o` follows for one cycle, with that byte on `opcode_o`.
- R8: For a general-line service, a captured byte of the form 11nnn111 gives `vec_addr_o` = n×8. Any other byte gives 0x0000.
- R9: The global enable is set by `ei_i` and cleared by `di_i`, and `di_i` wins when both are high. An accept clears it even when `ei_i` is high in the same cycle.
- R10: `irq_req_o` stays low from the cycle after an accept up to and including the `vec_valid_o` cycle.
- R11: Reset clears the global enable, sets all three mask bits, clears the pending flag, holds `inta_n_o` high and `vec_valid_o` low. A `rst75_i` that is already high at reset release does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable request, level |
| rst75_i | input | 1 | Edge-captured restart request |
| rst65_i | input | 1 | Restart request B, level |
| rst55_i | input | 1 | Restart request C, level |
| intr_i | input | 1 | General request, level |
| ei_i | input | 1 | Set-global-enable strobe |
| di_i | input | 1 | Clear-global-enable strobe |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_i | input | 3 | Mask value (1 = masked) |
| take_i | input | 1 | Core accepts the present request |
| data_i | input | 8 | Data bus, instruction byte during acknowledge |
| irq_req_o | output | 1 | An eligible request is waiting |
| inta_n_o | output | 1 | Acknowledge pulse, active low |
| vec_valid_o | output | 1 | Service address valid strobe |
| vec_addr_o | output | 16 | Service address |
| src_o | output | 5 | One-hot accepted source |
| opcode_o | output | 8 | Captured instruction byte |

## Verification
Two actions can land in the same cycle. An accept clears the global enable while `ei_i` sets it. An accept of the edge line clears its pending flag while a fresh rising edge sets it. Directed cases drive each pair in one cycle. The bench then judges the outcome at the ports: the next request must stay low for the first pair, and a second service of the edge line must follow for the second. The random phase keeps toggling strobes and lines around accepts, so these collisions also recur. Every cycle is compared with a bench-side model of enable, mask and pending state.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC     = 5;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int MASK_W   = 3;
  localparam int SRC_TRAP = 0;
  localparam int SRC_E75  = 1;
  localparam int SRC_L65  = 2;
  localparam int SRC_L55  = 3;
  localparam int SRC_GEN  = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK  = 2'd1,
    SEQ_VEC  = 2'd2
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] fixed_vec(input logic [NSRC-1:0] src);
    logic [ADDR_W-1:0] v;
    v = '0;
    if (src[SRC_TRAP])     v = 16'h0024;
    else if (src[SRC_E75]) v = 16'h003C;
    else if (src[SRC_L65]) v = 16'h0034;
    else if (src[SRC_L55]) v = 16'h002C;
    return v;
  endfunction

  function automatic logic [ADDR_W-1:0] restart_vec(input logic [DATA_W-1:0] op);
    logic [ADDR_W-1:0] v;
    v = '0;
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111)
      v = {{(ADDR_W-6){1'b0}}, op[5:3], 3'b000};
    return v;
  endfunction
endpackage

// File: rtl/irqv_edge_pend.sv
module irqv_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic lvl_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  always_comb begin
    rise   = lvl_i & ~lvl_q;
    pend_d = rise | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R4: an edge always leaves the flag set, even against a clear
  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i && !lvl_q) |=> pend_q);
  // R4: without a clear the flag holds
  a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/irqv_prio_sel.sv
module irqv_prio_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | req_i[i];
    assign grant_o[i] = req_i[i] & ~seen[i];
  end

  // R1: at most one winner, and only among requesters
  always_comb begin
    if (!$isunknown(req_i))
      a_r1_grant_onehot: assert ($onehot0(grant_o) && ((grant_o & ~req_i) == '0));
  end
endmodule

// File: rtl/irqv_ack_seq.sv
module irqv_ack_seq
  import irqv_pkg::*;
#(
  parameter int INTA_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NSRC-1:0]   grant_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              inta_n_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [NSRC-1:0]   src_o,
  output logic [DATA_W-1:0] opcode_o
);
  localparam int CW = (INTA_CYCLES < 2) ? 1 : $clog2(INTA_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(INTA_CYCLES - 1);

  seq_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NSRC-1:0]   src_q;
  logic [DATA_W-1:0] opc_q;
  logic              src_en;
  logic              opc_en;
  logic              cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    src_en = 1'b0;
    opc_en = 1'b0;
    cnt_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start_i) begin
          src_en = 1'b1;
          if (grant_i[SRC_GEN]) begin
            st_d   = SEQ_ACK;
            cnt_d  = CNT_LAST;
            cnt_en = 1'b1;
          end else begin
            st_d = SEQ_VEC;
          end
        end
      end
      SEQ_ACK: begin
        if (cnt_q == '0) begin
          opc_en = 1'b1;
          st_d   = SEQ_VEC;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      SEQ_VEC: st_d = SEQ_IDLE;
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      src_q <= '0;
      opc_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (src_en) src_q <= grant_i;
      if (opc_en) opc_q <= data_i;
    end
  end

  always_comb begin
    busy_o      = (st_q != SEQ_IDLE);
    inta_n_o    = (st_q != SEQ_ACK);
    vec_valid_o = (st_q == SEQ_VEC);
    src_o       = src_q;
    opcode_o    = opc_q;
    vec_addr_o  = src_q[SRC_GEN] ? restart_vec(opc_q) : fixed_vec(src_q);
  end

  // R7: a general-line accept starts the acknowledge pulse next cycle
  a_r7_inta_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && start_i && grant_i[SRC_GEN]) |=> !inta_n_o);
  // R2: the valid strobe lasts a single cycle
  a_r2_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);
  // R2: a fixed-source accept yields the strobe next cycle
  a_r2_fixed_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && start_i && !grant_i[SRC_GEN]) |=> vec_valid_o);

  // R7: pulse length bounded by INTA_CYCLES, checked with a run counter
  logic [CW:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run_q <= '0;
    else if (!inta_n_o) low_run_q <= low_run_q + 1'b1;
    else                low_run_q <= '0;
  end
  a_r7_inta_len: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run_q <= (CW+1)'(INTA_CYCLES)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int INTA_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_i,
  input  logic        rst75_i,
  input  logic        rst65_i,
  input  logic        rst55_i,
  input  logic        intr_i,
  input  logic        ei_i,
  input  logic        di_i,
  input  logic        mask_wr_i,
  input  logic [2:0]  mask_i,
  input  logic        take_i,
  input  logic [7:0]  data_i,
  output logic        irq_req_o,
  output logic        inta_n_o,
  output logic        vec_valid_o,
  output logic [15:0] vec_addr_o,
  output logic [4:0]  src_o,
  output logic [7:0]  opcode_o
);
  logic              ien_q, ien_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              pend75;
  logic              busy;
  logic              accept;
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   grant;

  irqv_edge_pend u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (rst75_i),
    .clr_i  (accept & grant[SRC_E75]),
    .pend_o (pend75)
  );

  always_comb begin
    elig[SRC_TRAP] = trap_i;
    elig[SRC_E75]  = ien_q & pend75  & ~mask_q[2];
    elig[SRC_L65]  = ien_q & rst65_i & ~mask_q[1];
    elig[SRC_L55]  = ien_q & rst55_i & ~mask_q[0];
    elig[SRC_GEN]  = ien_q & intr_i;
  end

  irqv_prio_sel #(.N(NSRC)) u_prio (
    .req_i   (elig),
    .grant_o (grant)
  );

  always_comb begin
    irq_req_o = (|elig) & ~busy;
    accept    = take_i & irq_req_o;
    if (accept)    ien_d = 1'b0;
    else if (di_i) ien_d = 1'b0;
    else if (ei_i) ien_d = 1'b1;
    else           ien_d = ien_q;
    mask_d = mask_wr_i ? mask_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      ien_q  <= ien_d;
      mask_q <= mask_d;
    end
  end

  irqv_ack_seq #(.INTA_CYCLES(INTA_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .grant_i     (grant),
    .data_i      (data_i),
    .busy_o      (busy),
    .inta_n_o    (inta_n_o),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .src_o       (src_o),
    .opcode_o    (opcode_o)
  );

  // R9: accepting clears the enable, whatever the strobes do
  a_r9_accept_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ien_q);
  // R3: the non-maskable line always requests while idle
  a_r3_trap_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !busy) |-> irq_req_o);
  // R6: a general-line win needs the enable
  a_r6_gen_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grant[SRC_GEN]) |-> ien_q);
  // R10: no request between accept and the end of the strobe
  a_r10_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !irq_req_o);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int INTA = 2;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0;
  logic ei = 0, di = 0, mwr = 0, take = 0;
  logic [2:0] mask_in = '0;
  logic [7:0] data = '0;
  logic irq_req, inta_n, vec_valid;
  logic [15:0] vec_addr;
  logic [4:0] src;
  logic [7:0] opcode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic       m_ien, m_pend, m_prev;
  logic [2:0] m_mask;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.INTA_CYCLES(INTA)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
    .rst55_i(r55), .intr_i(intr), .ei_i(ei), .di_i(di), .mask_wr_i(mwr),
    .mask_i(mask_in), .take_i(take), .data_i(data), .irq_req_o(irq_req),
    .inta_n_o(inta_n), .vec_valid_o(vec_valid), .vec_addr_o(vec_addr),
    .src_o(src), .opcode_o(opcode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] elig_m();
    logic [4:0] e;
    e[0] = trap;
    e[1] = m_ien & m_pend & ~m_mask[2];
    e[2] = m_ien & r65 & ~m_mask[1];
    e[3] = m_ien & r55 & ~m_mask[0];
    e[4] = m_ien & intr;
    return e;
  endfunction

  function automatic logic [4:0] prio_m(input logic [4:0] e);
    for (int i = 0; i < 5; i++) if (e[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  function automatic logic [15:0] fvec_m(input logic [4:0] g);
    case (g)
      5'b00001: return 16'h0024;
      5'b00010: return 16'h003C;
      5'b00100: return 16'h0034;
      5'b01000: return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] rvec_m(input logic [7:0] op);
    if (op[7:6] == 2'b11 && op[2:0] == 3'b111) return 16'(op[5:3]) * 16'd8;
    return 16'h0000;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_seq(input logic [4:0] g);
    logic [7:0] op;
    op = 8'h00;
    if (g[4]) begin
      for (int k = 0; k < INTA; k++) begin
        chk(inta_n === 1'b0, "R7 acknowledge low", 32'(inta_n), 0);
        chk(irq_req === 1'b0, "R10 quiet in acknowledge", 32'(irq_req), 0);
        if (k == INTA - 1) begin
          op = (($urandom % 3) == 0) ? 8'hE7 : 8'($urandom);
          data = op;
        end else begin
          data = 8'($urandom);
        end
        step();
      end
      chk(inta_n === 1'b1, "R7 acknowledge ended", 32'(inta_n), 1);
      chk(opcode === op, "R7 captured byte", 32'(opcode), 32'(op));
      chk(vec_addr === rvec_m(op), "R8 restart address", 32'(vec_addr), 32'(rvec_m(op)));
    end else begin
      chk(vec_addr === fvec_m(g), "R2 fixed address", 32'(vec_addr), 32'(fvec_m(g)));
    end
    chk(vec_valid === 1'b1, "R2 R7 valid strobe", 32'(vec_valid), 1);
    chk(src === g, "R1 R2 source", 32'(src), 32'(g));
    chk(irq_req === 1'b0, "R10 quiet in strobe", 32'(irq_req), 0);
    step();
    chk(vec_valid === 1'b0, "R2 strobe one cycle", 32'(vec_valid), 0);
  endtask

  task automatic tick();
    logic [4:0] e, g;
    logic er, acc;
    #1;
    e = elig_m();
    er = |e;
    chk(irq_req === er, "R1 R3 R5 R6 R9 request", 32'(irq_req), 32'(er));
    acc = take & er;
    g = prio_m(e);
    step();
    m_pend = (r75 & ~m_prev) | (m_pend & ~(acc & g[1]));
    m_prev = r75;
    if (acc || di) m_ien = 1'b0;
    else if (ei)   m_ien = 1'b1;
    if (mwr) m_mask = mask_in;
    take = 0; ei = 0; di = 0; mwr = 0;
    if (acc) run_seq(g);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ien = 0; m_pend = 0; m_prev = 1; m_mask = 3'b111;
    r75 = 1; r65 = 1; r55 = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(inta_n === 1'b1, "R11 acknowledge idle", 32'(inta_n), 1);
    chk(vec_valid === 1'b0, "R11 no strobe", 32'(vec_valid), 0);
    rst_n = 1;
    // R11: held-high edge line is not an edge; masks set
    ei = 1; tick();
    tick();
    chk(irq_req === 1'b0, "R11 masked after reset", 32'(irq_req), 0);
    // R3: non-maskable line with enable cleared
    di = 1; tick();
    trap = 1; take = 1; tick();
    trap = 0;
    // R1: edge line beats B and C and general
    r75 = 0; intr = 1; mwr = 1; mask_in = 3'b000; ei = 1; tick();
    r75 = 1; tick();
    r75 = 0; take = 1; tick();
    // R9: enable cleared after accept
    tick();
    chk(irq_req === 1'b0, "R9 enable cleared by accept", 32'(irq_req), 0);
    // R9: accept wins over EI in same cycle
    ei = 1; tick();
    take = 1; ei = 1; tick();
    tick();
    chk(irq_req === 1'b0, "R9 accept beats enable strobe", 32'(irq_req), 0);
    // R4: new edge in the same cycle as the edge-line accept
    r75 = 1; ei = 1; tick();
    r75 = 0; tick();
    r75 = 1; take = 1; tick();
    ei = 1; tick();
    take = 1; tick();
    // R5 R6: mask B and C, general line wins past them
    r75 = 0; mwr = 1; mask_in = 3'b011; ei = 1; tick();
    take = 1; tick();
    // R9: DI wins over EI
    ei = 1; di = 1; tick();
    tick();
    chk(irq_req === 1'b0, "R9 disable beats enable", 32'(irq_req), 0);
    for (int n = 0; n < 800; n++) begin
      trap    = (($urandom % 16) == 0);
      r75     = 1'($urandom);
      r65     = 1'($urandom);
      r55     = 1'($urandom);
      intr    = (($urandom % 3) == 0);
      ei      = (($urandom % 4) == 0);
      di      = (($urandom % 8) == 0);
      mwr     = (($urandom % 8) == 0);
      mask_in = 3'($urandom);
      take    = 1'($urandom);
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule